// File: doc/BRIEF.md
# Comparator Event and Interrupt Controller

This block is the digital half of a bank of up to four analog comparators. Each comparator's raw output enters asynchronously. It is re-timed through a flop chain clocked by either the I/O clock or a fast PLL-derived clock, as chosen per comparator. The block then watches the re-timed level for the transition selected in that comparator's configuration. A matching transition sets a sticky event flag. The flag raises that comparator's interrupt request when the comparator and its interrupt are both enabled.

Software reaches the block through a plain register bus clocked by the I/O clock. The bus has an address, a write strobe, write data and combinational read data. It holds one 8-bit configuration register per comparator and one shared status register. The status register shows every re-timed output level and every event flag. Flags are cleared by writing ones. The 3-bit negative-input selection is stored and presented on a port for the analog multiplexer; this block does nothing else with it.

Top module: `cmp_evt_ctrl`

## Requirements
- R1: Configuration register of comparator i sits at address i (0 to 3) and reads back every written bit. The shared status register sits at address 4, and addresses 5 to 7 read as zero. Configuration bit layout: bit 7 enable, bit 6 interrupt enable, bits 5:4 trigger code, bit 3 clock select, bits 2:0 negative-input code.
- R2: After reset every configuration bit, every flag, every interrupt request and every negative-input code is 0.
- R3: Status bits 3:0 show the re-timed output level of comparators 0 to 3, whether or not the comparator is enabled. On the I/O-clock path, a raw change applied between edges is not yet flagged after two rising edges. It is flagged after the third rising edge.
- R4: Trigger code 00 flags any change of the level, 10 flags only 1-to-0, and 11 flags only 0-to-1. Code 01 never sets a flag.
- R5: With clock select 1 the level is taken through the fast-clock re-timing chain. If the fast clock stops, the reported level and the flag stop following the raw input. With clock select 0 the I/O-clock chain is used.
- R6: A disabled comparator sets no flag. Enabling it while its input is steady sets no flag.
- R7: Status bits 7:4 are the flags of comparators 0 to 3 and stay set until a 1 is written to them at address 4. Writing 0 to a flag bit, or anything to bits 3:0, changes nothing.
- R8: A new event in the same cycle as a clear of that flag leaves the flag set.
- R9: irq[i] is high exactly when flag i, interrupt enable i and enable i are all 1.
- R10: neg_sel[3*i+2:3*i] equals bits 2:0 of configuration register i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_io | input | 1 | I/O clock; clocks the bus, flags and I/O re-timing chain |
| clk_fast | input | 1 | Fast PLL-derived sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset for both clocks |
| bus_addr | input | ADDR_W | Register address |
| bus_wr | input | 1 | Write strobe, sampled on clk_io |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr (combinational) |
| cmp_raw | input | NUM_CMP | Raw comparator outputs, asynchronous |
| neg_sel | output | 3*NUM_CMP | Negative-input select codes, 3 bits per comparator |
| irq | output | NUM_CMP | Per-comparator interrupt requests |

## Verification
The bench builds the block with its defaults: four comparators, a 3-bit address and two-flop re-timing chains. This puts the whole address space and every comparator within a short sweep. Every comparator is driven through all four trigger codes in both transition directions on the I/O path. The fast path is also swept, including a stopped fast clock. The small address space lets the bench read every location and check the status byte against a value it computes itself.

// File: rtl/cmp_evt_pkg.sv
package cmp_evt_pkg;

  typedef enum logic [1:0] {
    TRIG_ANY  = 2'b00,
    TRIG_RSVD = 2'b01,
    TRIG_FALL = 2'b10,
    TRIG_RISE = 2'b11
  } trig_e;

  // Field order matters: software sees it at bit positions 7..0.
  typedef struct packed {
    logic       en;
    logic       ie;
    trig_e      trig;
    logic       fast;
    logic [2:0] nsel;
  } cmp_cfg_t;

  localparam int CFG_W    = $bits(cmp_cfg_t);
  localparam int NSEL_W   = 3;
  localparam int FLAG_LSB = 4;

endpackage

// File: rtl/cmp_sync.sv
module cmp_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);

  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], d};
  end

  assign q = chain_q[STAGES-1];

endmodule

// File: rtl/cmp_channel.sv
module cmp_channel
  import cmp_evt_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic  clk_io,
  input  logic  clk_fast,
  input  logic  rst_n,
  input  logic  raw,
  input  logic  en,
  input  logic  fast_sel,
  input  trig_e trig,
  output logic  level,
  output logic  evt
);

  logic io_lvl;
  logic fast_lvl;
  logic fast_io_lvl;
  logic prev_q;
  logic rise;
  logic fall;
  logic hit;

  // I/O-clock sampling chain
  cmp_sync #(.STAGES(SYNC_STAGES)) u_sync_io (
    .clk   (clk_io),
    .rst_n (rst_n),
    .d     (raw),
    .q     (io_lvl)
  );

  // Fast-clock sampling chain, then carried into the I/O domain
  cmp_sync #(.STAGES(SYNC_STAGES)) u_sync_fast (
    .clk   (clk_fast),
    .rst_n (rst_n),
    .d     (raw),
    .q     (fast_lvl)
  );

  cmp_sync #(.STAGES(SYNC_STAGES)) u_sync_xfer (
    .clk   (clk_io),
    .rst_n (rst_n),
    .d     (fast_lvl),
    .q     (fast_io_lvl)
  );

  assign level = fast_sel ? fast_io_lvl : io_lvl;

  // Previous sample tracks the level in every cycle, enabled or not,
  // so enabling never compares against a stale value.
  always_ff @(posedge clk_io or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= level;
  end

  assign rise = level & ~prev_q;
  assign fall = ~level & prev_q;

  always_comb begin
    unique case (trig)
      TRIG_ANY:  hit = rise | fall;
      TRIG_FALL: hit = fall;
      TRIG_RISE: hit = rise;
      default:   hit = 1'b0;
    endcase
  end

  assign evt = en & hit;

endmodule

// File: rtl/cmp_regs.sv
module cmp_regs
  import cmp_evt_pkg::*;
#(
  parameter int NUM_CMP = 4,
  parameter int ADDR_W  = 3
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [ADDR_W-1:0]       addr,
  input  logic                    wr,
  input  logic [CFG_W-1:0]        wdata,
  output logic [CFG_W-1:0]        rdata,
  input  logic [NUM_CMP-1:0]      level,
  input  logic [NUM_CMP-1:0]      evt,
  output cmp_cfg_t [NUM_CMP-1:0]  cfg,
  output logic [NUM_CMP-1:0]      flag,
  output logic [NUM_CMP-1:0]      clr
);

  localparam int STAT_ADDR = NUM_CMP;

  logic stat_wr;

  assign stat_wr = wr && (addr == ADDR_W'(STAT_ADDR));

  for (genvar i = 0; i < NUM_CMP; i++) begin : g_lane
    logic cfg_wr;

    assign cfg_wr = wr && (addr == ADDR_W'(i));
    assign clr[i] = stat_wr && wdata[FLAG_LSB+i];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      cfg[i] <= '0;
      else if (cfg_wr) cfg[i] <= cmp_cfg_t'(wdata);
    end

    // Set wins over clear
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) flag[i] <= 1'b0;
      else        flag[i] <= evt[i] | (flag[i] & ~clr[i]);
    end
  end

  always_comb begin
    rdata = '0;
    for (int i = 0; i < NUM_CMP; i++) begin
      if (addr == ADDR_W'(i)) rdata = cfg[i];
    end
    if (addr == ADDR_W'(STAT_ADDR)) begin
      for (int i = 0; i < NUM_CMP; i++) begin
        rdata[i]          = level[i];
        rdata[FLAG_LSB+i] = flag[i];
      end
    end
  end

endmodule

// File: rtl/cmp_evt_ctrl.sv
module cmp_evt_ctrl
  import cmp_evt_pkg::*;
#(
  parameter int NUM_CMP     = 4,
  parameter int ADDR_W      = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic                      clk_io,
  input  logic                      clk_fast,
  input  logic                      rst_n,
  input  logic [ADDR_W-1:0]         bus_addr,
  input  logic                      bus_wr,
  input  logic [CFG_W-1:0]          bus_wdata,
  output logic [CFG_W-1:0]          bus_rdata,
  input  logic [NUM_CMP-1:0]        cmp_raw,
  output logic [NSEL_W*NUM_CMP-1:0] neg_sel,
  output logic [NUM_CMP-1:0]        irq
);

  cmp_cfg_t [NUM_CMP-1:0] cfg;
  logic [NUM_CMP-1:0]     level;
  logic [NUM_CMP-1:0]     evt;
  logic [NUM_CMP-1:0]     flag;
  logic [NUM_CMP-1:0]     clr;

  cmp_regs #(.NUM_CMP(NUM_CMP), .ADDR_W(ADDR_W)) u_regs (
    .clk   (clk_io),
    .rst_n (rst_n),
    .addr  (bus_addr),
    .wr    (bus_wr),
    .wdata (bus_wdata),
    .rdata (bus_rdata),
    .level (level),
    .evt   (evt),
    .cfg   (cfg),
    .flag  (flag),
    .clr   (clr)
  );

  for (genvar i = 0; i < NUM_CMP; i++) begin : g_cmp
    cmp_channel #(.SYNC_STAGES(SYNC_STAGES)) u_chan (
      .clk_io   (clk_io),
      .clk_fast (clk_fast),
      .rst_n    (rst_n),
      .raw      (cmp_raw[i]),
      .en       (cfg[i].en),
      .fast_sel (cfg[i].fast),
      .trig     (cfg[i].trig),
      .level    (level[i]),
      .evt      (evt[i])
    );

    assign neg_sel[NSEL_W*i +: NSEL_W] = cfg[i].nsel;
    assign irq[i] = flag[i] & cfg[i].ie & cfg[i].en;
  end

endmodule

// File: rtl/cmp_evt_chk.sv
module cmp_evt_chk #(
  parameter int NUM_CMP = 4
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic [8*NUM_CMP-1:0]   cfg_flat,
  input logic [NUM_CMP-1:0]     flag,
  input logic [NUM_CMP-1:0]     clr,
  input logic [NUM_CMP-1:0]     evt
);

  for (genvar i = 0; i < NUM_CMP; i++) begin : g_chk
    AST_EVT_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      evt[i] |=> flag[i]); // R3

    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      flag[i] && !clr[i] |=> flag[i]); // R7

    AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
      flag[i] && clr[i] && !evt[i] |=> !flag[i]); // R7

    AST_RSVD_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
      !flag[i] && cfg_flat[8*i+5 -: 2] == 2'b01 && !clr[i] |=> !flag[i]); // R4

    AST_OFF_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
      !flag[i] && !cfg_flat[8*i+7] |=> !flag[i]); // R6

    AST_SET_BEATS_CLR: assert property (@(posedge clk) disable iff (!rst_n)
      evt[i] && clr[i] |=> flag[i]); // R8
  end

endmodule

bind cmp_evt_ctrl cmp_evt_chk #(.NUM_CMP(NUM_CMP)) u_chk (
  .clk      (clk_io),
  .rst_n    (rst_n),
  .cfg_flat (cfg),
  .flag     (flag),
  .clr      (clr),
  .evt      (evt)
);

// File: tb/cmp_evt_ctrl_tb.sv
`timescale 1ns/1ps
module cmp_evt_ctrl_tb;

  localparam int N  = 4;
  localparam int AW = 3;

  logic         clk_io = 1'b0;
  logic         clk_fast = 1'b0;
  logic         fast_run = 1'b1;
  logic         rst_n = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic         bus_wr = 1'b0;
  logic [7:0]   bus_wdata = '0;
  logic [7:0]   bus_rdata;
  logic [N-1:0] cmp_raw = '0;
  logic [3*N-1:0] neg_sel;
  logic [N-1:0] irq;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2.5 clk_io = ~clk_io;
  always #1 if (fast_run) clk_fast = ~clk_fast;

  cmp_evt_ctrl #(.NUM_CMP(N), .ADDR_W(AW), .SYNC_STAGES(2)) u_dut (
    .clk_io    (clk_io),
    .clk_fast  (clk_fast),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .cmp_raw   (cmp_raw),
    .neg_sel   (neg_sel),
    .irq       (irq)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input int d);
    @(negedge clk_io);
    bus_addr = AW'(a); bus_wdata = 8'(d); bus_wr = 1'b1;
    @(negedge clk_io);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input int a, output int d);
    @(negedge clk_io);
    bus_addr = AW'(a);
    #0.5 d = int'(bus_rdata);
  endtask

  task automatic cyc(input int n);
    repeat (n) @(posedge clk_io);
  endtask

  initial begin
    int s;
    repeat (3) @(posedge clk_io);
    rst_n = 1'b1;

    // R2: reset state
    for (int a = 0; a < N; a++) begin
      rd(a, s); chk("R2 cfg", s, 0);
    end
    rd(4, s); chk("R2 flags", s >> 4, 0);
    chk("R2 irq", int'(irq), 0);
    chk("R10 reset neg_sel", int'(neg_sel), 0);

    // R1/R10: readback and select codes
    for (int i = 0; i < N; i++) begin
      wr(i, 8'h35 + 8'h11 * i);
    end
    for (int i = 0; i < N; i++) begin
      rd(i, s); chk("R1 readback", s, 8'h35 + 8'h11 * i);
      chk("R10 neg_sel", int'(neg_sel[3*i +: 3]), (8'h35 + 8'h11 * i) & 7);
    end
    for (int a = 5; a < 8; a++) begin
      rd(a, s); chk("R1 unmapped", s, 0);
    end
    for (int i = 0; i < N; i++) wr(i, 0);

    // R3/R4/R9: I/O path sweep over channels, codes, directions
    for (int i = 0; i < N; i++) begin
      for (int m = 0; m < 4; m++) begin
        for (int d = 0; d < 2; d++) begin
          bit fin = d[0];
          bit ef;
          wr(i, 8'hC0 | (m << 4));
          cmp_raw[i] = ~fin;
          cyc(4);
          wr(4, 8'hF0);
          cmp_raw[i] = fin;
          cyc(4);
          rd(4, s);
          ef = (m == 0) || (m == 2 && !fin) || (m == 3 && fin);
          chk("R4 flags", (s >> 4) & 15, int'(ef) << i);
          chk("R3 level", (s >> i) & 1, int'(fin));
          chk("R9 irq", int'(irq[i]), int'(ef));
        end
      end
      wr(i, 0);
    end

    // R5: fast-clock path
    for (int i = 0; i < N; i++) begin
      for (int m = 0; m < 4; m += 3) begin
        wr(i, 8'hC8 | (m << 4));
        cmp_raw[i] = 1'b0;
        cyc(12);
        wr(4, 8'hF0);
        cmp_raw[i] = 1'b1;
        cyc(12);
        rd(4, s);
        chk("R5 fast flag", (s >> (4 + i)) & 1, 1);
        chk("R5 fast level", (s >> i) & 1, 1);
      end
      wr(i, 0);
    end
    wr(0, 8'hC8);
    cyc(12);
    wr(4, 8'hF0);
    fast_run = 1'b0;
    cmp_raw[0] = 1'b0;
    cyc(12);
    rd(4, s);
    chk("R5 stopped level", s & 1, 1);
    chk("R5 stopped flag", (s >> 4) & 1, 0);
    fast_run = 1'b1;
    cyc(12);
    rd(4, s);
    chk("R5 resumed level", s & 1, 0);
    chk("R5 resumed flag", (s >> 4) & 1, 1);
    wr(0, 0);

    // R6: disabled channel, then enable on steady input
    wr(4, 8'hF0);
    wr(1, 8'h40);
    cmp_raw[1] = ~cmp_raw[1];
    cyc(4);
    rd(4, s);
    chk("R6 off flag", (s >> 5) & 1, 0);
    chk("R3 off level", (s >> 1) & 1, int'(cmp_raw[1]));
    chk("R9 off irq", int'(irq[1]), 0);
    wr(1, 8'hC0);
    cyc(4);
    rd(4, s);
    chk("R6 enable no event", (s >> 5) & 1, 0);
    cmp_raw[1] = ~cmp_raw[1];
    cyc(4);
    rd(4, s);
    chk("R6 enabled event", (s >> 5) & 1, 1);

    // R9: interrupt masked, then unmasked
    wr(2, 8'h80);
    cmp_raw[2] = ~cmp_raw[2];
    cyc(4);
    rd(4, s);
    chk("R9 masked flag", (s >> 6) & 1, 1);
    chk("R9 masked irq", int'(irq[2]), 0);
    wr(2, 8'hC0);
    chk("R9 unmasked irq", int'(irq[2]), 1);

    // R7: write-one-to-clear
    wr(4, 8'h0F);
    rd(4, s);
    chk("R7 zero write", (s >> 4) & 15, 4'b0110);
    wr(4, 8'h20);
    rd(4, s);
    chk("R7 one clear", (s >> 4) & 15, 4'b0100);
    wr(4, 8'h00);
    rd(4, s);
    chk("R7 no-op write", (s >> 4) & 15, 4'b0100);
    wr(4, 8'hF0);
    rd(4, s);
    chk("R7 clear all", (s >> 4) & 15, 0);

    // R8: event and clear in the same cycle
    wr(0, 8'hC0);
    cmp_raw[0] = ~cmp_raw[0];
    cyc(4);
    @(negedge clk_io);
    cmp_raw[0] = ~cmp_raw[0];
    @(posedge clk_io);
    @(posedge clk_io);
    wr(4, 8'h10);
    rd(4, s);
    chk("R8 set beats clear", (s >> 4) & 1, 1);

    // R3: exact latency on the I/O path
    wr(3, 8'hC0);
    wr(4, 8'hF0);
    bus_addr = AW'(4);
    @(negedge clk_io);
    cmp_raw[3] = ~cmp_raw[3];
    @(posedge clk_io);
    @(posedge clk_io);
    @(negedge clk_io);
    chk("R3 two edges", int'(bus_rdata[7]), 0);
    @(negedge clk_io);
    chk("R3 third edge", int'(bus_rdata[7]), 1);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #500000;
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

endmodule